// File: doc/BRIEF.md
# UART Extended Register Access Controller

This block is the register front end of a 16550-style UART that carries an extended register set. It takes a host byte bus with a 3-bit address, 8-bit data and read and write strobes. The address is decoded together with the current line control value into one of three views. The normal view holds the everyday control registers. The divisor view exposes the baud divisor and, while that divisor is zero, two identification bytes. The extended view is opened by writing a key value into the line control register, and it holds the enhanced feature, feature control and trigger level registers. It also gives read access to the FIFO fill count.

A group of enhanced control bits spread over the interrupt enable, FIFO control and modem control registers can be changed only while the enhanced-enable bit of the enhanced feature register is 1. Clearing that bit freezes their values, so older software that rewrites these registers cannot disturb them. Every register value is driven out to the rest of the UART. The serial datapath, the FIFOs and the baud generator live elsewhere.

Top module: `uart_xreg_ctrl`

## Requirements
- R1: In the divisor view (LCR bit 7 = 1, LCR not 0xBF), writes to address 0 and 1 load the low and high divisor bytes, both read back there, and `divisor_o` = {high, low}.
- R2: When LCR = 0xBF, the extended view holds: address 2 is the enhanced feature register (EFR), address 5 is the feature control register (FCTR), and addresses 0/1 still reach the divisor. EFR cannot be written in any other view.
- R3: In the divisor view, address 2 reads 0x14 and address 5 reads 0x01 when both divisor bytes are 0x00, and 0x00 otherwise.
- R4: IER bits 7:4, FCR bits 5:4 and MCR bits 7:5 take written values only while EFR bit 4 = 1, and they keep their values while it is 0. All other bits of those registers are always written. IER is at address 1 in the normal view, FCR at address 2 (write-only) in the normal and divisor views, and MCR at address 4 in the normal and divisor views.
- R5: Reset (rst_ni low) clears every register, including all guarded bits, to 0.
- R6: Address 7 outside the extended view: with FCTR bit 6 = 0 it is a read/write scratch byte. With FCTR bit 6 = 1, a read returns the FIFO count and a write loads `emsr_o` while the scratch byte is left unchanged.
- R7: The FIFO count source is `tx_cnt_i` when FCTR bit 7 = 1 and `rx_cnt_i` when it is 0. In the extended view, a write to address 4 loads the TX trigger level when FCTR bit 7 = 1 and the RX trigger level when it is 0, and a read of address 4 returns the count.
- R8: In the normal view, address 2 reads `isr_i`. Normal addresses 0, 5 and 6 and extended addresses 6 and 7 read 0x00. `rdata_o` is 0x00 whenever `rd_i` is low.
- R9: The LCR reads and writes at address 3 in every view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Host register address |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| rd_i | input | 1 | Read strobe, read data is combinational |
| rdata_o | output | 8 | Host read data |
| isr_i | input | 8 | Interrupt status from the UART core |
| tx_cnt_i | input | 8 | Transmit FIFO fill count |
| rx_cnt_i | input | 8 | Receive FIFO fill count |
| divisor_o | output | 16 | Baud divisor {high, low} |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| mcr_o | output | 8 | Modem control register |
| efr_o | output | 8 | Enhanced feature register |
| fctr_o | output | 8 | Feature control register |
| emsr_o | output | 8 | Enhanced mode register |
| trg_rx_o | output | 8 | RX trigger level |
| trg_tx_o | output | 8 | TX trigger level |

## Verification
All-ones bytes are written to IER and MCR with the guard closed and then with it open. This shows whether the guard masks exactly the upper fields and leaves the lower fields free. The guard is then closed again and zeros are written, which separates "held" from "cleared". The same addresses are read under LCR values 0x03, 0x80 and 0xBF to tell the three views apart. The identification reads are repeated with a zero and a non-zero divisor. The scratch location and the count/trigger location are exercised with both settings of the swap and direction bits, using distinct TX and RX counts so that a wrong count source shows up.

// File: rtl/uart_xreg_pkg.sv
package uart_xreg_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {VIEW_NORM, VIEW_DIV, VIEW_EXT} view_e;

  typedef struct packed {
    logic dll;
    logic dlm;
    logic ier;
    logic fcr;
    logic lcr;
    logic mcr;
    logic spr;
    logic emsr;
    logic efr;
    logic fctr;
    logic trg_rx;
    logic trg_tx;
  } wstb_t;

  localparam logic [AW-1:0] A_R0 = 3'd0;
  localparam logic [AW-1:0] A_R1 = 3'd1;
  localparam logic [AW-1:0] A_R2 = 3'd2;
  localparam logic [AW-1:0] A_R3 = 3'd3;
  localparam logic [AW-1:0] A_R4 = 3'd4;
  localparam logic [AW-1:0] A_R5 = 3'd5;
  localparam logic [AW-1:0] A_R6 = 3'd6;
  localparam logic [AW-1:0] A_R7 = 3'd7;
endpackage

// File: rtl/uart_xreg_decode.sv
module uart_xreg_decode
  import uart_xreg_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] EXT_KEY = 8'hBF,
  parameter int          SWAP_BIT = 6,
  parameter int          DIR_BIT  = 7
) (
  input  logic [DW-1:0] lcr_i,
  input  logic [DW-1:0] fctr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  output view_e         view_o,
  output wstb_t         wstb_o
);
  always_comb begin
    if (lcr_i == EXT_KEY)    view_o = VIEW_EXT;
    else if (lcr_i[DW-1])    view_o = VIEW_DIV;
    else                     view_o = VIEW_NORM;
  end

  always_comb begin
    wstb_o = '0;
    if (wr_i) begin
      unique case (addr_i)
        A_R0: wstb_o.dll = (view_o != VIEW_NORM);
        A_R1: begin
          wstb_o.dlm = (view_o != VIEW_NORM);
          wstb_o.ier = (view_o == VIEW_NORM);
        end
        A_R2: begin
          wstb_o.efr = (view_o == VIEW_EXT);
          wstb_o.fcr = (view_o != VIEW_EXT);
        end
        A_R3: wstb_o.lcr = 1'b1;
        A_R4: begin
          wstb_o.mcr    = (view_o != VIEW_EXT);
          wstb_o.trg_tx = (view_o == VIEW_EXT) && fctr_i[DIR_BIT];
          wstb_o.trg_rx = (view_o == VIEW_EXT) && !fctr_i[DIR_BIT];
        end
        A_R5: wstb_o.fctr = (view_o == VIEW_EXT);
        A_R6: ;
        A_R7: begin
          wstb_o.spr  = (view_o != VIEW_EXT) && !fctr_i[SWAP_BIT];
          wstb_o.emsr = (view_o != VIEW_EXT) && fctr_i[SWAP_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_xreg_guard_reg.sv
// Byte register; bits set in GUARD_MASK only update while unlock_i is high.
module uart_xreg_guard_reg #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] GUARD_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          unlock_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic upd;
    if (GUARD_MASK[i]) begin : g_guarded
      assign upd = we_i && unlock_i;
    end else begin : g_free
      assign upd = we_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_o[i] <= 1'b0;
      else if (upd) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/uart_xreg_rdmux.sv
module uart_xreg_rdmux
  import uart_xreg_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] DEV_ID   = 8'h14,
  parameter logic [DW-1:0] DEV_REV  = 8'h01,
  parameter int            SWAP_BIT = 6,
  parameter int            DIR_BIT  = 7
) (
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  view_e         view_i,
  input  logic [DW-1:0] dll_i,
  input  logic [DW-1:0] dlm_i,
  input  logic [DW-1:0] ier_i,
  input  logic [DW-1:0] lcr_i,
  input  logic [DW-1:0] mcr_i,
  input  logic [DW-1:0] spr_i,
  input  logic [DW-1:0] efr_i,
  input  logic [DW-1:0] fctr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] tx_cnt_i,
  input  logic [DW-1:0] rx_cnt_i,
  output logic [DW-1:0] rdata_o
);
  logic          div_zero;
  logic [DW-1:0] cnt_sel;
  logic [DW-1:0] mux;

  assign div_zero = ~|{dlm_i, dll_i};
  assign cnt_sel  = fctr_i[DIR_BIT] ? tx_cnt_i : rx_cnt_i;

  always_comb begin
    mux = '0;
    unique case (addr_i)
      A_R0: if (view_i != VIEW_NORM) mux = dll_i;
      A_R1: mux = (view_i == VIEW_NORM) ? ier_i : dlm_i;
      A_R2: begin
        unique case (view_i)
          VIEW_NORM: mux = isr_i;
          VIEW_DIV:  mux = div_zero ? DEV_ID : '0;
          default:   mux = efr_i;
        endcase
      end
      A_R3: mux = lcr_i;
      A_R4: mux = (view_i == VIEW_EXT) ? cnt_sel : mcr_i;
      A_R5: begin
        if (view_i == VIEW_DIV)      mux = div_zero ? DEV_REV : '0;
        else if (view_i == VIEW_EXT) mux = fctr_i;
      end
      A_R6: ;
      A_R7: if (view_i != VIEW_EXT) mux = fctr_i[SWAP_BIT] ? cnt_sel : spr_i;
      default: ;
    endcase
  end

  assign rdata_o = rd_i ? mux : '0;
endmodule

// File: rtl/uart_xreg_ctrl.sv
module uart_xreg_ctrl
  import uart_xreg_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] EXT_KEY   = 8'hBF,
  parameter logic [DW-1:0] DEV_ID    = 8'h14,
  parameter logic [DW-1:0] DEV_REV   = 8'h01,
  parameter logic [DW-1:0] IER_GUARD = 8'hF0,
  parameter logic [DW-1:0] FCR_GUARD = 8'h30,
  parameter logic [DW-1:0] MCR_GUARD = 8'hE0,
  parameter int            UNLOCK_BIT = 4,
  parameter int            SWAP_BIT   = 6,
  parameter int            DIR_BIT    = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wr_i,
  input  logic            rd_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [DW-1:0]   isr_i,
  input  logic [DW-1:0]   tx_cnt_i,
  input  logic [DW-1:0]   rx_cnt_i,
  output logic [2*DW-1:0] divisor_o,
  output logic [DW-1:0]   lcr_o,
  output logic [DW-1:0]   ier_o,
  output logic [DW-1:0]   fcr_o,
  output logic [DW-1:0]   mcr_o,
  output logic [DW-1:0]   efr_o,
  output logic [DW-1:0]   fctr_o,
  output logic [DW-1:0]   emsr_o,
  output logic [DW-1:0]   trg_rx_o,
  output logic [DW-1:0]   trg_tx_o
);
  localparam int NREG = 12;
  localparam logic [DW-1:0] NO_GUARD = '0;

  view_e         view;
  wstb_t         wstb;
  logic          unlock;
  logic [DW-1:0] dll, dlm, spr;
  logic [DW-1:0] q   [NREG];
  logic [NREG-1:0] we;

  uart_xreg_decode #(
    .DW(DW), .EXT_KEY(EXT_KEY), .SWAP_BIT(SWAP_BIT), .DIR_BIT(DIR_BIT)
  ) i_decode (
    .lcr_i (lcr_o),
    .fctr_i(fctr_o),
    .addr_i(addr_i),
    .wr_i  (wr_i),
    .view_o(view),
    .wstb_o(wstb)
  );

  assign unlock = efr_o[UNLOCK_BIT];
  assign we = {wstb.dll, wstb.dlm, wstb.ier, wstb.fcr, wstb.lcr, wstb.mcr,
               wstb.spr, wstb.emsr, wstb.efr, wstb.fctr, wstb.trg_rx, wstb.trg_tx};

  // Index k maps to we[NREG-1-k]: 0 dll,1 dlm,2 ier,3 fcr,4 lcr,5 mcr,6 spr,7 emsr,8 efr,9 fctr,10 trg_rx,11 trg_tx
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [DW-1:0] MASK = (k == 2) ? IER_GUARD :
                                     (k == 3) ? FCR_GUARD :
                                     (k == 5) ? MCR_GUARD : NO_GUARD;
    uart_xreg_guard_reg #(.DW(DW), .GUARD_MASK(MASK)) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we[NREG-1-k]),
      .unlock_i(unlock),
      .d_i     (wdata_i),
      .q_o     (q[k])
    );
  end

  assign dll      = q[0];
  assign dlm      = q[1];
  assign ier_o    = q[2];
  assign fcr_o    = q[3];
  assign lcr_o    = q[4];
  assign mcr_o    = q[5];
  assign spr      = q[6];
  assign emsr_o   = q[7];
  assign efr_o    = q[8];
  assign fctr_o   = q[9];
  assign trg_rx_o = q[10];
  assign trg_tx_o = q[11];
  assign divisor_o = {dlm, dll};

  uart_xreg_rdmux #(
    .DW(DW), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .SWAP_BIT(SWAP_BIT), .DIR_BIT(DIR_BIT)
  ) i_rdmux (
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .view_i  (view),
    .dll_i   (dll),
    .dlm_i   (dlm),
    .ier_i   (ier_o),
    .lcr_i   (lcr_o),
    .mcr_i   (mcr_o),
    .spr_i   (spr),
    .efr_i   (efr_o),
    .fctr_i  (fctr_o),
    .isr_i   (isr_i),
    .tx_cnt_i(tx_cnt_i),
    .rx_cnt_i(rx_cnt_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/uart_xreg_ctrl_chk.sv
module uart_xreg_ctrl_chk #(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] EXT_KEY = 8'hBF
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      addr_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic [DW-1:0]   rdata_o,
  input logic [2*DW-1:0] divisor_o,
  input logic [DW-1:0]   lcr_o,
  input logic [DW-1:0]   ier_o,
  input logic [DW-1:0]   fcr_o,
  input logic [DW-1:0]   mcr_o,
  input logic [DW-1:0]   efr_o,
  input logic [DW-1:0]   fctr_o,
  input logic [DW-1:0]   emsr_o
);
  AST_GUARD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !efr_o[4] |=> ($stable(ier_o[7:4]) && $stable(fcr_o[5:4]) && $stable(mcr_o[7:5]))); // R4

  AST_DIV_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(divisor_o)); // R1

  AST_EFR_OUTSIDE_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcr_o != EXT_KEY) |=> $stable(efr_o)); // R2

  AST_ID_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == 3'd2 || addr_i == 3'd5) && lcr_o[DW-1] && lcr_o != EXT_KEY
     && divisor_o != '0) |-> rdata_o == '0); // R3

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0); // R8

  AST_SPR_NO_EMSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd7 && !fctr_o[6]) |=> $stable(emsr_o)); // R6
endmodule

bind uart_xreg_ctrl uart_xreg_ctrl_chk #(.DW(DW), .EXT_KEY(EXT_KEY)) i_chk (.*);

// File: tb/test_uart_xreg_ctrl.sv
module test_uart_xreg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [7:0]  isr = 8'hC1;
  logic [7:0]  tx_cnt = 8'h55;
  logic [7:0]  rx_cnt = 8'h2A;
  logic [15:0] divisor;
  logic [7:0]  lcr, ier, fcr, mcr, efr, fctr, emsr, trg_rx, trg_tx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_xreg_ctrl i_uart_xreg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .isr_i(isr), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .divisor_o(divisor), .lcr_o(lcr), .ier_o(ier), .fcr_o(fcr), .mcr_o(mcr),
    .efr_o(efr), .fctr_o(fctr), .emsr_o(emsr), .trg_rx_o(trg_rx), .trg_tx_o(trg_tx)
  );

  typedef struct packed {
    logic       is_rd;
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd3, 8'h00, 4'd5},  // R5 LCR after reset
    '{1'b0, 3'd1, 8'hFF, 4'd4},  // R4 IER write, guard closed
    '{1'b1, 3'd1, 8'h0F, 4'd4},
    '{1'b0, 3'd4, 8'hFF, 4'd4},  // R4 MCR write, guard closed
    '{1'b1, 3'd4, 8'h1F, 4'd4},
    '{1'b0, 3'd3, 8'h80, 4'd3},  // divisor view
    '{1'b1, 3'd2, 8'h14, 4'd3},  // R3 ID with zero divisor
    '{1'b1, 3'd5, 8'h01, 4'd3},  // R3 revision
    '{1'b0, 3'd0, 8'h34, 4'd1},
    '{1'b1, 3'd0, 8'h34, 4'd1},  // R1
    '{1'b1, 3'd2, 8'h00, 4'd3},  // R3 ID hidden, divisor nonzero
    '{1'b1, 3'd5, 8'h00, 4'd3},
    '{1'b0, 3'd1, 8'h12, 4'd1},
    '{1'b1, 3'd1, 8'h12, 4'd1},  // R1
    '{1'b0, 3'd3, 8'hBF, 4'd9},
    '{1'b1, 3'd3, 8'hBF, 4'd9},  // R9
    '{1'b0, 3'd2, 8'h10, 4'd2},  // R2 EFR unlock
    '{1'b1, 3'd2, 8'h10, 4'd2},
    '{1'b1, 3'd0, 8'h34, 4'd2},  // R2 divisor still at 0 in extended view
    '{1'b0, 3'd5, 8'h40, 4'd2},  // FCTR swap on, RX direction
    '{1'b1, 3'd5, 8'h40, 4'd2},
    '{1'b0, 3'd4, 8'h07, 4'd7},  // R7 RX trigger
    '{1'b1, 3'd4, 8'h2A, 4'd7},  // R7 RX count
    '{1'b1, 3'd6, 8'h00, 4'd8},  // R8 extended 6
    '{1'b1, 3'd7, 8'h00, 4'd8},  // R8 extended 7
    '{1'b0, 3'd3, 8'h03, 4'd9},
    '{1'b1, 3'd3, 8'h03, 4'd9},
    '{1'b0, 3'd1, 8'hFF, 4'd4},  // R4 guard open
    '{1'b1, 3'd1, 8'hFF, 4'd4},
    '{1'b0, 3'd4, 8'hFF, 4'd4},
    '{1'b1, 3'd4, 8'hFF, 4'd4},
    '{1'b0, 3'd2, 8'hFF, 4'd4},  // FCR write
    '{1'b1, 3'd2, 8'hC1, 4'd8},  // R8 ISR read
    '{1'b1, 3'd7, 8'h2A, 4'd6},  // R6 swap read gives RX count
    '{1'b0, 3'd7, 8'h99, 4'd6},  // R6 goes to enhanced mode reg
    '{1'b1, 3'd0, 8'h00, 4'd8},  // R8 normal 0
    '{1'b1, 3'd6, 8'h00, 4'd8}   // R8 normal 6
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    check(req, {8'h00, rdata}, {8'h00, exp}, $sformatf("read addr %0d", a));
    rd = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state at the ports
    check(5, {ier, fcr}, 16'h0000, "ier/fcr after reset");
    check(5, {mcr, efr}, 16'h0000, "mcr/efr after reset");
    check(5, divisor, 16'h0000, "divisor after reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) bus_rd(VEC[i].a, VEC[i].d, int'(VEC[i].req));
      else              bus_wr(VEC[i].a, VEC[i].d);
    end

    // R1 divisor port, R4 FCR port, R6 emsr, R7 trigger
    check(1, divisor, 16'h1234, "divisor_o");
    check(4, {8'h00, fcr}, 16'h00FF, "fcr_o guard open");
    check(6, {8'h00, emsr}, 16'h0099, "emsr_o");
    check(7, {trg_rx, trg_tx}, 16'h0700, "trg_rx/trg_tx");

    // R4 close guard, then clear writes: guarded bits hold
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd1, 8'hF0, 4);
    bus_wr(3'd4, 8'h00);
    bus_rd(3'd4, 8'hE0, 4);
    bus_wr(3'd2, 8'h00);
    check(4, {8'h00, fcr}, 16'h0030, "fcr_o guard closed");
    // R2 EFR write outside extended view ignored
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd2, 8'h10);
    check(2, {8'h00, efr}, 16'h0000, "efr_o after divisor-view write");

    // R6 swap off: plain scratch, emsr untouched
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd5, 8'h00);
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd7, 8'h5A);
    bus_rd(3'd7, 8'h5A, 6);
    check(6, {8'h00, emsr}, 16'h0099, "emsr_o held");
    // R6 swap on with TX direction; scratch kept
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd5, 8'hC0);
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd7, 8'h55, 6);
    bus_wr(3'd7, 8'h11);
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd5, 8'h80);
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd7, 8'h5A, 6);

    // R7 TX direction in extended view
    bus_wr(3'd3, 8'hBF);
    bus_rd(3'd4, 8'h55, 7);
    bus_wr(3'd4, 8'h09);
    check(7, {trg_rx, trg_tx}, 16'h0709, "trg after TX write");

    // R8 idle read
    @(negedge clk);
    addr = 3'd3; rd = 1'b0; #1;
    check(8, {8'h00, rdata}, 16'h0000, "rdata with rd low");

    // R5 reset mid-run clears guarded and other bits
    bus_wr(3'd2, 8'h10);
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd1, 8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(5, {ier, mcr}, 16'h0000, "ier/mcr after reset");
    check(5, {fcr, efr}, 16'h0000, "fcr/efr after reset");
    check(5, divisor, 16'h0000, "divisor after reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule